// File: doc/BRIEF.md
# Tagged Reservation Station Wakeup

This block buffers micro-operations between dispatch and a single execution port. It holds them until both source operands are present, then sends one ready operation per cycle to the port. Each slot stores an opcode and two operands. An operand arrives either with its value or with the rename tag of the instruction that will produce it. Each slot also stores a destination rename pointer, a mask of unresolved branch tags the operation depends on, and a flag that marks it as sent. Results from execution are broadcast back on a tag/data bus. Every waiting operand whose producer tag matches the broadcast takes the data at once.

Branch resolution works per tag. A mispredicted tag removes only the slots whose mask has that bit set. A correctly predicted tag simply clears that bit in every slot. Speculation never delays issue: a slot with unresolved branch bits issues as soon as its operands are ready. When several slots are ready, the one dispatched earliest goes first. Dispatch must hold off while the full flag is high.

Top module: `rs_wakeup_station`

## Requirements
- R1: After reset no slot holds an operation, `iss_valid` is 0 and `full` is 0.
- R2: A dispatch is written into a free slot. `full` is 1 exactly when every slot holds an operation. A dispatch presented while `full` is 1 is dropped and never issues.
- R3: A slot issues only when both operands are available. The issue outputs carry its opcode, both operand values and its destination pointer one clock after the edge at which it was selected.
- R4: The branch-tag mask plays no part in readiness, so a slot whose mask is nonzero issues in the same cycle a clean slot would.
- R5: When `wake_valid` is 1, every waiting operand whose stored tag (the low TAG_W bits of the operand field, used when its ready bit is 0) equals `wake_tag` takes `wake_data` and becomes available at that clock edge.
- R6: A dispatch whose waiting operand matches the broadcast in the same cycle stores the broadcast value and counts as available.
- R7: At most one operation issues per cycle. Among ready slots the one dispatched earliest is chosen.
- R8: Each operation issues exactly once. Its slot is released one cycle after the issue edge and can be reused after that.
- R9: A mispredict on tag index k (bit k of the mask) removes every slot, and any dispatch in the same cycle, whose mask bit k is 1. All others are untouched.
- R10: A correct prediction on tag index k clears mask bit k in every slot and in a dispatch of the same cycle. An operation issued in that cycle leaves with the bit already cleared on `iss_spec`.
- R11: When a kill hits a slot in the same cycle as a wakeup or a selection for that slot, the kill wins and the operation never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode |
| disp_a_rdy | input | 1 | Operand A holds a value (1) or a producer tag (0) |
| disp_a | input | DATA_W | Operand A value or tag in low bits |
| disp_b_rdy | input | 1 | Operand B holds a value (1) or a producer tag (0) |
| disp_b | input | DATA_W | Operand B value or tag in low bits |
| disp_dst | input | TAG_W | Destination rename pointer |
| disp_spec | input | SPEC_W | Unresolved branch-tag mask |
| full | output | 1 | No free slot; dispatch must stall |
| wake_valid | input | 1 | Result broadcast present |
| wake_tag | input | TAG_W | Producer tag of the broadcast |
| wake_data | input | DATA_W | Broadcast result value |
| kill_valid | input | 1 | Mispredict resolution |
| kill_idx | input | SPEC_IDX_W | Mispredicted branch tag index |
| clear_valid | input | 1 | Correct-prediction resolution |
| clear_idx | input | SPEC_IDX_W | Resolved branch tag index |
| iss_valid | output | 1 | Issue outputs hold an operation |
| iss_op | output | OP_W | Issued opcode |
| iss_a | output | DATA_W | Issued operand A |
| iss_b | output | DATA_W | Issued operand B |
| iss_dst | output | TAG_W | Issued destination pointer |
| iss_spec | output | SPEC_W | Issued branch-tag mask |

## Verification
The bench targets several corner cases, each tied to a specific failure it would expose:
- A broadcast landing in the same cycle as the dispatch it should satisfy. If the dispatch path skips the bus, that operation waits forever.
- Kills that coincide with a wakeup, with a selection, or with a dispatch carrying the tag. If the kill loses, a squashed operation reaches the issue port.
- A full station that receives one more dispatch. A wrong full flag would overwrite a live slot or lose the count.
- Several operations woken by one broadcast. A wrong age order would issue them out of dispatch order or two in one cycle.
- A clear that coincides with an issue. If that case is missed, a resolved bit leaks out on `iss_spec`.

A behavioural model with sequence numbers runs beside the design, and its outputs are compared every cycle across a long random mix of all of these events.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_DEPTH  = 8;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_TAG_W  = 4;
  localparam int unsigned DEF_OP_W   = 4;
  localparam int unsigned DEF_SPEC_W = 4;

  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned OP_W       = 4,
  parameter int unsigned SPEC_W     = 4,
  parameter int unsigned SPEC_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [OP_W-1:0]       wr_op,
  input  logic                  wr_a_rdy,
  input  logic [DATA_W-1:0]     wr_a,
  input  logic                  wr_b_rdy,
  input  logic [DATA_W-1:0]     wr_b,
  input  logic [TAG_W-1:0]      wr_dst,
  input  logic [SPEC_W-1:0]     wr_spec,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic [DATA_W-1:0]     wake_data,
  input  logic                  kill_valid,
  input  logic [SPEC_IDX_W-1:0] kill_idx,
  input  logic                  clear_valid,
  input  logic [SPEC_IDX_W-1:0] clear_idx,
  input  logic                  issue_sel,
  output logic                  valid,
  output logic                  ready,
  output logic [OP_W-1:0]       op,
  output logic [DATA_W-1:0]     a,
  output logic [DATA_W-1:0]     b,
  output logic [TAG_W-1:0]      dst,
  output logic [SPEC_W-1:0]     spec
);
  logic valid_q, issued_q, a_rdy_q, b_rdy_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [TAG_W-1:0]  dst_q;
  logic [SPEC_W-1:0] spec_q, kill_mask, clr_mask;
  logic kill_now, wr_killed, a_hit, b_hit, a_hit_wr, b_hit_wr;

  always_comb begin
    kill_mask = '0;
    clr_mask  = '0;
    if (kill_valid)  kill_mask[kill_idx]  = 1'b1;
    if (clear_valid) clr_mask[clear_idx]  = 1'b1;
  end

  assign kill_now  = valid_q && |(spec_q & kill_mask);
  assign wr_killed = |(wr_spec & kill_mask);
  assign a_hit     = !a_rdy_q && wake_valid && (a_q[TAG_W-1:0] == wake_tag);
  assign b_hit     = !b_rdy_q && wake_valid && (b_q[TAG_W-1:0] == wake_tag);
  assign a_hit_wr  = !wr_a_rdy && wake_valid && (wr_a[TAG_W-1:0] == wake_tag);
  assign b_hit_wr  = !wr_b_rdy && wake_valid && (wr_b[TAG_W-1:0] == wake_tag);

  // Control state: kill takes priority over release and issue marking.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      a_rdy_q  <= 1'b0;
      b_rdy_q  <= 1'b0;
      spec_q   <= '0;
    end else begin
      if (wr_en) begin
        valid_q  <= !wr_killed;
        issued_q <= 1'b0;
        a_rdy_q  <= wr_a_rdy || a_hit_wr;
        b_rdy_q  <= wr_b_rdy || b_hit_wr;
        spec_q   <= wr_spec & ~clr_mask;
      end else begin
        if (kill_now || (valid_q && issued_q)) valid_q <= 1'b0;
        else if (valid_q && issue_sel)         issued_q <= 1'b1;
        if (a_hit) a_rdy_q <= 1'b1;
        if (b_hit) b_rdy_q <= 1'b1;
        spec_q <= spec_q & ~clr_mask;
      end
    end
  end

  // Payload: plain write-enabled storage, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      op_q  <= wr_op;
      dst_q <= wr_dst;
      a_q   <= a_hit_wr ? wake_data : wr_a;
      b_q   <= b_hit_wr ? wake_data : wr_b;
    end else begin
      if (a_hit) a_q <= wake_data;
      if (b_hit) b_q <= wake_data;
    end
  end

  assign valid = valid_q;
  assign ready = valid_q && !issued_q && a_rdy_q && b_rdy_q && !kill_now;
  assign op    = op_q;
  assign a     = a_q;
  assign b     = b_q;
  assign dst   = dst_q;
  assign spec  = spec_q;

  a_r8_free_after_issue: assert property (@(posedge clk) disable iff (rst)
    (valid_q && issued_q) |=> !valid_q);
  a_r9_kill_drops: assert property (@(posedge clk) disable iff (rst)
    kill_now |=> !valid_q);
  a_r10_tag_cleared: assert property (@(posedge clk) disable iff (rst)
    clear_valid |=> !spec_q[$past(clear_idx)]);
  a_r3_issue_needs_operands: assert property (@(posedge clk) disable iff (rst)
    $rose(issued_q) |-> $past(a_rdy_q && b_rdy_q));
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] alloc,
  input  logic [DEPTH-1:0] ready,
  output logic [DEPTH-1:0] grant
);
  // older_q[j][i] = 1 means slot j was written before slot i.
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < DEPTH; r++) older_q[r] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            if (j != k) begin
              older_q[j][k] <= 1'b1;
              older_q[k][j] <= 1'b0;
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (ready[j] && older_q[j][i]) blocked = 1'b1;
      grant[i] = ready[i] && !blocked;
    end
  end

  a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             req,
  input  logic [DEPTH-1:0] valid,
  output logic [DEPTH-1:0] alloc,
  output logic             full
);
  always_comb begin
    alloc = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        alloc    = '0;
        alloc[i] = req;
      end
    end
  end

  assign full = &valid;
endmodule

// File: rtl/rs_wakeup_station.sv
module rs_wakeup_station #(
  parameter int unsigned DEPTH  = rs_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned OP_W   = rs_pkg::DEF_OP_W,
  parameter int unsigned SPEC_W = rs_pkg::DEF_SPEC_W,
  localparam int unsigned SPEC_IDX_W = rs_pkg::idx_width(SPEC_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  disp_valid,
  input  logic [OP_W-1:0]       disp_op,
  input  logic                  disp_a_rdy,
  input  logic [DATA_W-1:0]     disp_a,
  input  logic                  disp_b_rdy,
  input  logic [DATA_W-1:0]     disp_b,
  input  logic [TAG_W-1:0]      disp_dst,
  input  logic [SPEC_W-1:0]     disp_spec,
  output logic                  full,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic [DATA_W-1:0]     wake_data,
  input  logic                  kill_valid,
  input  logic [SPEC_IDX_W-1:0] kill_idx,
  input  logic                  clear_valid,
  input  logic [SPEC_IDX_W-1:0] clear_idx,
  output logic                  iss_valid,
  output logic [OP_W-1:0]       iss_op,
  output logic [DATA_W-1:0]     iss_a,
  output logic [DATA_W-1:0]     iss_b,
  output logic [TAG_W-1:0]      iss_dst,
  output logic [SPEC_W-1:0]     iss_spec
);
  logic [DEPTH-1:0]  e_valid, e_ready, alloc, grant;
  logic [OP_W-1:0]   e_op   [DEPTH];
  logic [DATA_W-1:0] e_a    [DEPTH];
  logic [DATA_W-1:0] e_b    [DEPTH];
  logic [TAG_W-1:0]  e_dst  [DEPTH];
  logic [SPEC_W-1:0] e_spec [DEPTH];

  rs_alloc #(.DEPTH(DEPTH)) u_alloc (
    .req(disp_valid), .valid(e_valid), .alloc(alloc), .full(full)
  );

  rs_age_select #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst(rst), .alloc(alloc), .ready(e_ready), .grant(grant)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
      .SPEC_W(SPEC_W), .SPEC_IDX_W(SPEC_IDX_W)
    ) u_entry (
      .clk(clk), .rst(rst),
      .wr_en(alloc[g]), .wr_op(disp_op),
      .wr_a_rdy(disp_a_rdy), .wr_a(disp_a),
      .wr_b_rdy(disp_b_rdy), .wr_b(disp_b),
      .wr_dst(disp_dst), .wr_spec(disp_spec),
      .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_data(wake_data),
      .kill_valid(kill_valid), .kill_idx(kill_idx),
      .clear_valid(clear_valid), .clear_idx(clear_idx),
      .issue_sel(grant[g]),
      .valid(e_valid[g]), .ready(e_ready[g]),
      .op(e_op[g]), .a(e_a[g]), .b(e_b[g]), .dst(e_dst[g]), .spec(e_spec[g])
    );
  end

  logic [OP_W-1:0]   m_op;
  logic [DATA_W-1:0] m_a, m_b;
  logic [TAG_W-1:0]  m_dst;
  logic [SPEC_W-1:0] m_spec, clr_mask;

  always_comb begin
    m_op = '0; m_a = '0; m_b = '0; m_dst = '0; m_spec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        m_op   |= e_op[i];
        m_a    |= e_a[i];
        m_b    |= e_b[i];
        m_dst  |= e_dst[i];
        m_spec |= e_spec[i];
      end
    end
    clr_mask = '0;
    if (clear_valid) clr_mask[clear_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_a     <= '0;
      iss_b     <= '0;
      iss_dst   <= '0;
      iss_spec  <= '0;
    end else begin
      iss_valid <= |grant;
      if (|grant) begin
        iss_op   <= m_op;
        iss_a    <= m_a;
        iss_b    <= m_b;
        iss_dst  <= m_dst;
        iss_spec <= m_spec & ~clr_mask;
      end
    end
  end

  a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> (alloc == '0));
  a_r10_issue_spec_clean: assert property (@(posedge clk) disable iff (rst)
    (clear_valid && |grant) |=> !iss_spec[$past(clear_idx)]);
endmodule

// File: tb/test_rs_wakeup_station.sv
module test_rs_wakeup_station;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        d_valid = 0, d_ar = 0, d_br = 0;
  logic [3:0]  d_op = 0, d_dst = 0, d_spec = 0;
  logic [15:0] d_a = 0, d_b = 0;
  logic        w_v = 0, k_v = 0, c_v = 0;
  logic [3:0]  w_tag = 0;
  logic [15:0] w_data = 0;
  logic [1:0]  k_idx = 0, c_idx = 0;

  logic        full, iss_valid;
  logic [3:0]  iss_op, iss_dst, iss_spec;
  logic [15:0] iss_a, iss_b;

  rs_wakeup_station i_rs_wakeup_station (
    .clk(clk), .rst(rst),
    .disp_valid(d_valid), .disp_op(d_op), .disp_a_rdy(d_ar), .disp_a(d_a),
    .disp_b_rdy(d_br), .disp_b(d_b), .disp_dst(d_dst), .disp_spec(d_spec),
    .full(full),
    .wake_valid(w_v), .wake_tag(w_tag), .wake_data(w_data),
    .kill_valid(k_v), .kill_idx(k_idx), .clear_valid(c_v), .clear_idx(c_idx),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .iss_dst(iss_dst), .iss_spec(iss_spec)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural model: slots with sequence numbers for age.
  bit          mv [DEPTH];
  bit          mi [DEPTH];
  bit          mar[DEPTH];
  bit          mbr[DEPTH];
  logic [3:0]  mop[DEPTH], mdst[DEPTH], mspec[DEPTH];
  logic [15:0] ma [DEPTH], mb [DEPTH];
  int          mseq[DEPTH];
  int          seq_ctr = 0;

  bit          e_iv, e_full;
  logic [3:0]  e_op, e_dst, e_spec;
  logic [15:0] e_a, e_b;

  int lg_op[$];
  int lg_a [$];
  int lg_spec[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] km, cm;
    int best, slot;
    km = k_v ? (4'b1 << k_idx) : 4'b0;
    cm = c_v ? (4'b1 << c_idx) : 4'b0;
    best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mv[i] && !mi[i] && mar[i] && mbr[i] && ((mspec[i] & km) == 0))
        if (best < 0 || mseq[i] < mseq[best]) best = i;
    e_iv = (best >= 0);
    if (best >= 0) begin
      e_op = mop[best]; e_a = ma[best]; e_b = mb[best];
      e_dst = mdst[best]; e_spec = mspec[best] & ~cm;
    end
    slot = -1;
    if (d_valid)
      for (int i = 0; i < DEPTH; i++)
        if (!mv[i] && slot < 0) slot = i;
    for (int i = 0; i < DEPTH; i++) begin
      if (mv[i]) begin
        if (((mspec[i] & km) != 0) || mi[i]) mv[i] = 0;
        else begin
          if (i == best) mi[i] = 1;
          if (w_v && !mar[i] && ma[i][3:0] == w_tag) begin mar[i] = 1; ma[i] = w_data; end
          if (w_v && !mbr[i] && mb[i][3:0] == w_tag) begin mbr[i] = 1; mb[i] = w_data; end
        end
      end
      mspec[i] = mspec[i] & ~cm;
    end
    if (slot >= 0 && ((d_spec & km) == 0)) begin
      mv[slot] = 1; mi[slot] = 0; mop[slot] = d_op; mdst[slot] = d_dst;
      mar[slot] = d_ar || (w_v && d_a[3:0] == w_tag);
      ma[slot]  = (!d_ar && w_v && d_a[3:0] == w_tag) ? w_data : d_a;
      mbr[slot] = d_br || (w_v && d_b[3:0] == w_tag);
      mb[slot]  = (!d_br && w_v && d_b[3:0] == w_tag) ? w_data : d_b;
      mspec[slot] = d_spec & ~cm;
      mseq[slot] = seq_ctr;
      seq_ctr++;
    end
    e_full = 1;
    for (int i = 0; i < DEPTH; i++) if (!mv[i]) e_full = 0;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    check(iss_valid == e_iv, "R7", "iss_valid", iss_valid, e_iv);
    if (iss_valid && e_iv) begin
      check(iss_op == e_op && iss_dst == e_dst, "R3", "op/dst",
            {iss_op, iss_dst}, {e_op, e_dst});
      check(iss_a == e_a && iss_b == e_b, "R5", "operands",
            {iss_a, iss_b}, {e_a, e_b});
      check(iss_spec == e_spec, "R10", "iss_spec", iss_spec, e_spec);
    end
    check(full == e_full, "R2 R8", "full", full, e_full);
    if (iss_valid) begin
      lg_op.push_back(iss_op); lg_a.push_back(iss_a); lg_spec.push_back(iss_spec);
    end
    d_valid = 0; w_v = 0; k_v = 0; c_v = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic disp(input logic [3:0] op, input bit ar, input logic [15:0] a,
                      input bit br, input logic [15:0] b, input logic [3:0] spec);
    d_valid = 1; d_op = op; d_ar = ar; d_a = a; d_br = br; d_b = b;
    d_dst = op; d_spec = spec;
  endtask

  task automatic wake(input logic [3:0] tag, input logic [15:0] data);
    w_v = 1; w_tag = tag; w_data = data;
  endtask

  task automatic clear_log();
    lg_op.delete(); lg_a.delete(); lg_spec.delete();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mi[i] = 0; mspec[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check(iss_valid == 0 && full == 0, "R1", "reset outputs", {iss_valid, full}, 0);

    // R3, R5: waits for tag 5, then wakes.
    disp(4'h2, 0, 16'h0005, 1, 16'h0007, 4'h0); cycle();
    idle(3);
    check(lg_op.size() == 0, "R3", "issued while waiting", lg_op.size(), 0);
    wake(4'h5, 16'h0055); cycle();
    idle(3);
    check(lg_op.size() == 1 && lg_a[0] == 'h55, "R5", "woken operand",
          lg_a.size() ? lg_a[0] : -1, 'h55);
    clear_log();

    // R6: wake in the dispatch cycle.
    disp(4'h3, 0, 16'h0006, 1, 16'h0001, 4'h0); wake(4'h6, 16'h0066); cycle();
    idle(3);
    check(lg_op.size() == 1 && lg_a[0] == 'h66, "R6", "same-cycle capture",
          lg_a.size() ? lg_a[0] : -1, 'h66);
    clear_log();

    // R4: speculative entry issues.
    disp(4'h4, 1, 16'h0011, 1, 16'h0022, 4'b0010); cycle();
    idle(2);
    check(lg_op.size() == 1 && lg_spec[0] == 2, "R4", "speculative issue",
          lg_spec.size() ? lg_spec[0] : -1, 2);
    clear_log();

    // R7, R8: three waiting on tag 9, order of dispatch.
    for (int i = 1; i <= 3; i++) begin disp(i[3:0], 0, 16'h0009, 1, 16'h0, 4'h0); cycle(); end
    wake(4'h9, 16'h0099); cycle();
    idle(5);
    check(lg_op.size() == 3, "R8", "issue count", lg_op.size(), 3);
    check(lg_op.size() == 3 && lg_op[0] == 1 && lg_op[1] == 2 && lg_op[2] == 3,
          "R7", "age order", lg_op.size() == 3 ? lg_op[0]*256 + lg_op[1]*16 + lg_op[2] : -1, 'h123);
    clear_log();

    // R2: fill, overflow dispatch dropped.
    for (int i = 0; i < DEPTH; i++) begin disp(4'h1, 0, 16'h000A, 1, 16'h0, 4'h0); cycle(); end
    check(full == 1, "R2", "full after fill", full, 1);
    disp(4'hF, 1, 16'h0, 1, 16'h0, 4'h0); cycle();
    wake(4'hA, 16'h00AA); cycle();
    idle(DEPTH + 3);
    check(lg_op.size() == DEPTH, "R2", "drain count", lg_op.size(), DEPTH);
    begin
      int bad = 0;
      foreach (lg_op[i]) if (lg_op[i] == 'hF) bad++;
      check(bad == 0, "R2", "dropped dispatch issued", bad, 0);
    end
    check(full == 0, "R8", "slots released", full, 0);
    clear_log();

    // R9: kill tag 0 hits only op 4.
    disp(4'h4, 0, 16'h000B, 1, 16'h0, 4'b0001); cycle();
    disp(4'h5, 0, 16'h000B, 1, 16'h0, 4'b0010); cycle();
    disp(4'h6, 0, 16'h000B, 1, 16'h0, 4'b0000); cycle();
    k_v = 1; k_idx = 0; cycle();
    wake(4'hB, 16'h00BB); cycle();
    idle(4);
    check(lg_op.size() == 2 && lg_op[0] == 5 && lg_op[1] == 6, "R9", "survivors",
          lg_op.size(), 2);
    clear_log();

    // R11: kill with wake, kill with selection, kill with dispatch.
    disp(4'h7, 0, 16'h000C, 1, 16'h0, 4'b0100); cycle();
    wake(4'hC, 16'h00CC); k_v = 1; k_idx = 2; cycle();
    disp(4'h8, 1, 16'h0, 1, 16'h0, 4'b0100); cycle();
    k_v = 1; k_idx = 2; cycle();
    disp(4'h9, 1, 16'h0, 1, 16'h0, 4'b0100); k_v = 1; k_idx = 2; cycle();
    idle(4);
    check(lg_op.size() == 0, "R11", "killed ops issued", lg_op.size(), 0);
    check(lg_op.size() == 0, "R9", "same-cycle dispatch kill", lg_op.size(), 0);
    clear_log();

    // R10: clear while waiting, and clear in dispatch/issue cycle.
    disp(4'hB, 0, 16'h000D, 1, 16'h0, 4'b1000); cycle();
    c_v = 1; c_idx = 3; cycle();
    wake(4'hD, 16'h00DD); cycle();
    idle(3);
    disp(4'hC, 1, 16'h1, 1, 16'h2, 4'b1001); c_v = 1; c_idx = 3; cycle();
    c_v = 1; c_idx = 0; cycle();
    idle(2);
    check(lg_op.size() == 2 && lg_spec[0] == 0 && lg_spec[1] == 0, "R10",
          "cleared masks", lg_spec.size(), 2);
    clear_log();

    // Random mix against the model.
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 2 == 0) begin
        disp(4'($urandom), ($urandom % 3) != 0, 16'($urandom),
             ($urandom % 3) != 0, 16'($urandom), 4'($urandom & $urandom));
      end
      if ($urandom % 2 == 0) wake(4'($urandom), 16'($urandom));
      if ($urandom % 16 == 0) begin k_v = 1; k_idx = 2'($urandom); end
      if ($urandom % 8 == 0)  begin c_v = 1; c_idx = 2'($urandom); end
      cycle();
    end
    finish_run();
  end
endmodule